// File: doc/BRIEF.md
# Spin-Phase Folding Averager

This block folds a slow stream of signed 16-bit measurement samples (nominally 20 per second) into phase bins tied to a once-per-revolution spin reference pulse. With a 2 Hz spin there are ten samples per turn, so bin k collects every sample taken k sample slots after the reference pulse. Over many turns, each bin holds a running sum and a hit count. Dividing one by the other gives the spin-synchronous average at that phase, and any effect not locked to the spin averages away.

The same samples also drive a lock-in style detector at the spin frequency. Each accepted sample is multiplied by a cosine and a sine weight chosen by its bin, and the products are added into in-phase and quadrature sums. Samples that the upstream chain flags as out of scale keep their time slot but add nothing. A synchronous clear restarts the whole measurement. A revolution counter reports how many complete turns have been folded in, and a sticky flag reports saturation.

A reader picks a bin with a select input. The sum, count and truncated average of that bin appear combinationally on the read outputs.

Top module: `spin_fold_avg`

## Requirements
- R1: After reset, every bin sum and count, both correlation sums, the revolution count and the overflow flag are zero, and the block is unarmed.
- R2: Samples that arrive before the first reference pulse after a reset or clear are discarded. A reference pulse sets the phase to bin 0, and a sample in the same cycle goes to bin 0. Each sample taken while armed (out of scale or not) moves the next bin up by one, and the bin holds at bin NBINS-1 if a turn runs long.
- R3: A valid, in-scale, armed sample adds its value to the sum of its bin and adds one to that bin's count.
- R4: A sample with the out-of-scale flag set changes no bin sum, no count and no correlation sum.
- R5: Each reference pulse received while already armed adds one to the revolution count, which holds at its maximum value.
- R6: An accepted sample x in bin k adds x*C(k) to the in-phase sum and x*S(k) to the quadrature sum. Here C(k) = round(16384*cos(2*pi*k/10)) and S(k) = round(16384*sin(2*pi*k/10)).
- R7: The read outputs show the sum and count of the selected bin in the same cycle. The average is sum/count truncated toward zero and clamped to the 16-bit signed range, and it reads 0 when the count is 0. A select value of NBINS or above reads all zeros.
- R8: A bin sum that would leave the signed ACC_W-bit range is clamped at the limit it crossed, and the sticky overflow flag is set. A count holds at its all-ones value.
- R9: Clear is synchronous and overrides a reference pulse or a sample in the same cycle. It returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clr | input | 1 | Synchronous clear / restart |
| spin_ref | input | 1 | Once-per-revolution phase pulse |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed sample |
| smp_oor | input | 1 | Sample out of scale, do not accumulate |
| rd_bin | input | BIN_W | Bin selected for readout |
| rd_sum | output | ACC_W | Signed sum of the selected bin |
| rd_cnt | output | CNT_W | Hit count of the selected bin |
| rd_avg | output | SAMPLE_W | Signed truncated average of the selected bin |
| iq_i | output | CORR_W | In-phase correlation sum |
| iq_q | output | CORR_W | Quadrature correlation sum |
| rev_cnt | output | REV_W | Completed revolutions |
| ovf_flag | output | 1 | Sticky saturation flag |

## Verification
Each sums, counts, revolution and flag register takes effect at the first rising edge after the strobe that causes it. The readout mux and the divider add no latency, so every result is due one edge after its stimulus. The bench drives inputs and compares all outputs at falling edges, against a model that it advances at the rising edge in between, so each comparison sees exactly one edge of new state. A peek changes only the read select and waits a short delay inside the low clock phase, because the read path has no register.

// File: rtl/spin_avg_pkg.sv
package spin_avg_pkg;

  localparam int COEF_W      = 16;
  localparam int COEF_PHASES = 10;

  // cosine weight, Q1.14, ten phases per turn
  function automatic logic signed [COEF_W-1:0] cos_coef(input int unsigned k);
    case (k % COEF_PHASES)
      0:       cos_coef =  16'sd16384;
      1:       cos_coef =  16'sd13255;
      2:       cos_coef =  16'sd5063;
      3:       cos_coef = -16'sd5063;
      4:       cos_coef = -16'sd13255;
      5:       cos_coef = -16'sd16384;
      6:       cos_coef = -16'sd13255;
      7:       cos_coef = -16'sd5063;
      8:       cos_coef =  16'sd5063;
      default: cos_coef =  16'sd13255;
    endcase
  endfunction

  // sine weight, Q1.14, ten phases per turn
  function automatic logic signed [COEF_W-1:0] sin_coef(input int unsigned k);
    case (k % COEF_PHASES)
      0:       sin_coef =  16'sd0;
      1:       sin_coef =  16'sd9630;
      2:       sin_coef =  16'sd15582;
      3:       sin_coef =  16'sd15582;
      4:       sin_coef =  16'sd9630;
      5:       sin_coef =  16'sd0;
      6:       sin_coef = -16'sd9630;
      7:       sin_coef = -16'sd15582;
      8:       sin_coef = -16'sd15582;
      default: sin_coef = -16'sd9630;
    endcase
  endfunction

  // clamp a value into a signed field of w bits
  function automatic longint clamp_to(input longint v, input int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (v > hi)      clamp_to = hi;
    else if (v < lo) clamp_to = lo;
    else             clamp_to = v;
  endfunction

  // truncating average, zero for an empty bin
  function automatic longint avg_of(input longint s, input longint c, input int w);
    if (c == 0) avg_of = 0;
    else        avg_of = clamp_to(s / c, w);
  endfunction

endpackage

// File: rtl/phase_indexer.sv
module phase_indexer #(
  parameter int NBINS = 10,
  parameter int REV_W = 16,
  localparam int BIN_W = $clog2(NBINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             spin_ref,
  input  logic             smp_vld,
  output logic [BIN_W-1:0] eff_bin,
  output logic             eff_armed,
  output logic [REV_W-1:0] rev_cnt
);

  localparam logic [BIN_W-1:0] LAST_BIN = BIN_W'(NBINS - 1);

  logic [BIN_W-1:0] cur_bin;
  logic             armed;
  logic [REV_W-1:0] rev_q;

  // a reference pulse in this cycle places the sample at phase 0
  assign eff_bin   = spin_ref ? '0 : cur_bin;
  assign eff_armed = armed | spin_ref;
  assign rev_cnt   = rev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_bin <= '0;
      armed   <= 1'b0;
      rev_q   <= '0;
    end else if (clr) begin
      cur_bin <= '0;
      armed   <= 1'b0;
      rev_q   <= '0;
    end else begin
      if (spin_ref) armed <= 1'b1;
      if (spin_ref && armed && !(&rev_q)) rev_q <= rev_q + 1'b1;
      if (smp_vld && eff_armed)
        cur_bin <= (eff_bin == LAST_BIN) ? eff_bin : eff_bin + 1'b1;
      else if (spin_ref)
        cur_bin <= '0;
    end
  end

  a_r2_bin_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cur_bin <= LAST_BIN);
  a_r2_ref_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (spin_ref && !clr && !smp_vld) |=> (cur_bin == '0));
  a_r5_rev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !spin_ref) |=> $stable(rev_q));
  a_r9_index_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!armed && cur_bin == '0 && rev_q == '0));

endmodule

// File: rtl/bin_store.sv
module bin_store import spin_avg_pkg::*; #(
  parameter int NBINS    = 10,
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 32,
  parameter int CNT_W    = 16,
  localparam int BIN_W   = $clog2(NBINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                acc_en,
  input  logic [BIN_W-1:0]    acc_bin,
  input  logic [SAMPLE_W-1:0] acc_data,
  input  logic [BIN_W-1:0]    rd_bin,
  output logic [ACC_W-1:0]    rd_sum,
  output logic [CNT_W-1:0]    rd_cnt,
  output logic [SAMPLE_W-1:0] rd_avg,
  output logic                ovf_evt,
  output logic                ovf_flag
);

  localparam logic signed [ACC_W-1:0] SUM_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SUM_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] sum_q [NBINS];
  logic [CNT_W-1:0]        cnt_q [NBINS];

  logic signed [ACC_W-1:0] sel_sum;
  logic [CNT_W-1:0]        sel_cnt;
  logic signed [ACC_W:0]   wide_sum;
  logic                    pos_ovf, neg_ovf;
  logic signed [ACC_W-1:0] new_sum;
  logic [CNT_W-1:0]        new_cnt;
  logic                    ovf_q;

  // single shared adder: pick the addressed bin
  always_comb begin
    sel_sum = '0;
    sel_cnt = '0;
    for (int i = 0; i < NBINS; i++) begin
      if (acc_bin == BIN_W'(i)) begin
        sel_sum = sum_q[i];
        sel_cnt = cnt_q[i];
      end
    end
  end

  assign wide_sum = {sel_sum[ACC_W-1], sel_sum}
                  + {{(ACC_W+1-SAMPLE_W){acc_data[SAMPLE_W-1]}}, acc_data};
  assign pos_ovf  = (wide_sum[ACC_W:ACC_W-1] == 2'b01);
  assign neg_ovf  = (wide_sum[ACC_W:ACC_W-1] == 2'b10);
  assign new_sum  = pos_ovf ? SUM_MAX : (neg_ovf ? SUM_MIN : wide_sum[ACC_W-1:0]);
  assign new_cnt  = (&sel_cnt) ? sel_cnt : sel_cnt + 1'b1;
  assign ovf_evt  = acc_en & (pos_ovf | neg_ovf);
  assign ovf_flag = ovf_q;

  for (genvar g = 0; g < NBINS; g++) begin : g_bin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q[g] <= '0;
        cnt_q[g] <= '0;
      end else if (clr) begin
        sum_q[g] <= '0;
        cnt_q[g] <= '0;
      end else if (acc_en && acc_bin == BIN_W'(g)) begin
        sum_q[g] <= new_sum;
        cnt_q[g] <= new_cnt;
      end
    end

    a_r3_untouched_bin_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !(acc_en && acc_bin == BIN_W'(g))) |=> ($stable(sum_q[g]) && $stable(cnt_q[g])));
    a_r8_count_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && acc_en && acc_bin == BIN_W'(g) && (&cnt_q[g])) |=> (&cnt_q[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_q <= 1'b0;
    else if (clr)     ovf_q <= 1'b0;
    else if (ovf_evt) ovf_q <= 1'b1;
  end

  // readout mux and divider
  logic rd_hit;
  always_comb begin
    rd_hit = 1'b0;
    rd_sum = '0;
    rd_cnt = '0;
    for (int i = 0; i < NBINS; i++) begin
      if (rd_bin == BIN_W'(i)) begin
        rd_hit = 1'b1;
        rd_sum = sum_q[i];
        rd_cnt = cnt_q[i];
      end
    end
  end

  assign rd_avg = rd_hit ? SAMPLE_W'(avg_of(longint'($signed(rd_sum)), longint'(rd_cnt), SAMPLE_W))
                         : '0;

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr) |=> ovf_q);

endmodule

// File: rtl/lockin_corr.sv
module lockin_corr import spin_avg_pkg::*; #(
  parameter int SAMPLE_W = 16,
  parameter int CORR_W   = 48,
  parameter int NBINS    = 10,
  localparam int BIN_W   = $clog2(NBINS),
  localparam int PROD_W  = SAMPLE_W + COEF_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                acc_en,
  input  logic [BIN_W-1:0]    acc_bin,
  input  logic [SAMPLE_W-1:0] acc_data,
  output logic [CORR_W-1:0]   i_sum,
  output logic [CORR_W-1:0]   q_sum
);

  logic signed [COEF_W-1:0]   wc, ws;
  logic signed [SAMPLE_W-1:0] xs;
  logic signed [PROD_W-1:0]   pc, ps;

  assign wc = cos_coef({{(32-BIN_W){1'b0}}, acc_bin});
  assign ws = sin_coef({{(32-BIN_W){1'b0}}, acc_bin});
  assign xs = $signed(acc_data);
  assign pc = xs * wc;
  assign ps = xs * ws;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_sum <= '0;
      q_sum <= '0;
    end else if (clr) begin
      i_sum <= '0;
      q_sum <= '0;
    end else if (acc_en) begin
      i_sum <= i_sum + {{(CORR_W-PROD_W){pc[PROD_W-1]}}, pc};
      q_sum <= q_sum + {{(CORR_W-PROD_W){ps[PROD_W-1]}}, ps};
    end
  end

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !acc_en) |=> ($stable(i_sum) && $stable(q_sum)));

endmodule

// File: rtl/spin_fold_avg.sv
module spin_fold_avg #(
  parameter int NBINS    = 10,
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 32,
  parameter int CNT_W    = 16,
  parameter int REV_W    = 16,
  parameter int CORR_W   = 48,
  localparam int BIN_W   = $clog2(NBINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                spin_ref,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                smp_oor,
  input  logic [BIN_W-1:0]    rd_bin,
  output logic [ACC_W-1:0]    rd_sum,
  output logic [CNT_W-1:0]    rd_cnt,
  output logic [SAMPLE_W-1:0] rd_avg,
  output logic [CORR_W-1:0]   iq_i,
  output logic [CORR_W-1:0]   iq_q,
  output logic [REV_W-1:0]    rev_cnt,
  output logic                ovf_flag
);

  // named internal events
  logic [BIN_W-1:0] eff_bin;
  logic             eff_armed;
  logic             acc_en;
  logic             ovf_evt;

  assign acc_en = smp_vld & eff_armed & ~smp_oor & ~clr;

  phase_indexer #(.NBINS(NBINS), .REV_W(REV_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .spin_ref(spin_ref), .smp_vld(smp_vld),
    .eff_bin(eff_bin), .eff_armed(eff_armed), .rev_cnt(rev_cnt)
  );

  bin_store #(.NBINS(NBINS), .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_bins (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc_en(acc_en), .acc_bin(eff_bin),
    .acc_data(smp_data), .rd_bin(rd_bin), .rd_sum(rd_sum), .rd_cnt(rd_cnt),
    .rd_avg(rd_avg), .ovf_evt(ovf_evt), .ovf_flag(ovf_flag)
  );

  lockin_corr #(.SAMPLE_W(SAMPLE_W), .CORR_W(CORR_W), .NBINS(NBINS)) u_corr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc_en(acc_en), .acc_bin(eff_bin),
    .acc_data(smp_data), .i_sum(iq_i), .q_sum(iq_q)
  );

  a_r4_oor_no_corr: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && smp_oor && !clr) |=> ($stable(iq_i) && $stable(iq_q)));
  a_r8_evt_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !clr) |=> ovf_flag);
  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rev_cnt == '0 && !ovf_flag && iq_i == '0 && iq_q == '0));
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (rev_cnt == '0 && !ovf_flag));

endmodule

// File: tb/sim_spin_fold_avg.sv
module sim_spin_fold_avg;

  localparam int CLK_P = 10;
  localparam int NB = 10, SW = 16, AW = 24, CW = 8, RW = 4, QW = 48;
  localparam int BW = $clog2(NB);

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, spin_ref = 1'b0, smp_vld = 1'b0, smp_oor = 1'b0;
  logic [SW-1:0] smp_data = '0;
  logic [BW-1:0] rd_bin = '0;
  logic [AW-1:0] rd_sum;
  logic [CW-1:0] rd_cnt;
  logic [SW-1:0] rd_avg;
  logic [QW-1:0] iq_i, iq_q;
  logic [RW-1:0] rev_cnt;
  logic          ovf_flag;

  spin_fold_avg #(.NBINS(NB), .SAMPLE_W(SW), .ACC_W(AW), .CNT_W(CW), .REV_W(RW), .CORR_W(QW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .spin_ref(spin_ref), .smp_vld(smp_vld),
    .smp_data(smp_data), .smp_oor(smp_oor), .rd_bin(rd_bin), .rd_sum(rd_sum),
    .rd_cnt(rd_cnt), .rd_avg(rd_avg), .iq_i(iq_i), .iq_q(iq_q), .rev_cnt(rev_cnt),
    .ovf_flag(ovf_flag)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference
  longint m_sum[NB], m_cnt[NB], m_i, m_q, cw[NB], sw[NB];
  int     m_bin, m_rev;
  bit     m_armed, m_ovf;
  int     total = 0, bad = 0, rot = 0;
  bit     done = 0;
  longint SMAX = (longint'(1) <<< (AW-1)) - 1;
  longint SMIN = -(longint'(1) <<< (AW-1));

  task automatic model_clear();
    foreach (m_sum[k]) begin m_sum[k] = 0; m_cnt[k] = 0; end
    m_i = 0; m_q = 0; m_bin = 0; m_rev = 0; m_armed = 0; m_ovf = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n || clr) model_clear();
    else begin
      int k;
      longint x, s;
      k = spin_ref ? 0 : m_bin;
      x = longint'($signed(smp_data));
      if (spin_ref && m_armed && m_rev < (1 << RW) - 1) m_rev++;
      if (smp_vld && (m_armed || spin_ref)) begin
        if (!smp_oor) begin
          s = m_sum[k] + x;
          if (s > SMAX) begin s = SMAX; m_ovf = 1; end
          if (s < SMIN) begin s = SMIN; m_ovf = 1; end
          m_sum[k] = s;
          if (m_cnt[k] < (1 << CW) - 1) m_cnt[k]++;
          m_i += x * cw[k];
          m_q += x * sw[k];
        end
        m_bin = (k == NB-1) ? k : k + 1;
      end else if (spin_ref) m_bin = 0;
      if (spin_ref) m_armed = 1;
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint exp_avg(longint s, longint c);
    longint q;
    if (c == 0) return 0;
    q = s / c;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  task automatic check_all();
    int b;
    b = int'(rd_bin);
    if (b < NB) begin
      chk("R3 rd_sum", longint'($signed(rd_sum)), m_sum[b]);
      chk("R3 rd_cnt", longint'(rd_cnt), m_cnt[b]);
      chk("R7 rd_avg", longint'($signed(rd_avg)), exp_avg(m_sum[b], m_cnt[b]));
    end else begin
      chk("R7 idle bin sum", longint'($signed(rd_sum)), 0);
      chk("R7 idle bin cnt", longint'(rd_cnt), 0);
    end
    chk("R6 iq_i", longint'($signed(iq_i)), m_i);
    chk("R6 iq_q", longint'($signed(iq_q)), m_q);
    chk("R5 rev_cnt", longint'(rev_cnt), longint'(m_rev));
    chk("R8 ovf_flag", longint'(ovf_flag), longint'(m_ovf));
  endtask

  task automatic step(bit r, bit v, int x, bit o, bit c);
    @(negedge clk);
    check_all();
    spin_ref = r; smp_vld = v; smp_data = SW'(x); smp_oor = o; clr = c;
    rd_bin = BW'(rot); rot = (rot + 1) % 12;
  endtask

  task automatic peek(int b, output longint s, output longint n);
    @(negedge clk);
    check_all();
    spin_ref = 0; smp_vld = 0; smp_oor = 0; clr = 0; rd_bin = BW'(b);
    #1;
    s = longint'($signed(rd_sum));
    n = longint'(rd_cnt);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint s, n, s0, n0;
    int unsigned seed;
    seed = 32'h1234_5678;
    for (int k = 0; k < NB; k++) begin
      cw[k] = longint'($rtoi($floor(16384.0 * $cos(2.0 * 3.14159265358979 * k / 10.0) + 0.5)));
      sw[k] = longint'($rtoi($floor(16384.0 * $sin(2.0 * 3.14159265358979 * k / 10.0) + 0.5)));
    end
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset rev", longint'(rev_cnt), 0);
    chk("R1 reset ovf", longint'(ovf_flag), 0);
    chk("R1 reset iq_i", longint'(iq_i), 0);
    chk("R1 reset cnt", longint'(rd_cnt), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: unarmed samples discarded
    for (int j = 0; j < 5; j++) step(0, 1, 500, 0, 0);
    peek(0, s, n);
    chk("R2 unarmed drop", n, 0);

    // R2: same-cycle ref puts sample in bin 0, long turn piles into last bin
    step(1, 1, 7, 0, 0);
    for (int j = 0; j < 12; j++) step(0, 1, 3, 0, 0);
    peek(9, s, n);
    chk("R2 last bin pile", n, 4);
    peek(0, s, n);
    chk("R2 ref bin zero", s, 7);

    // mixed revolutions with a spin-rate sinusoid and noise
    for (int r = 0; r < 20; r++) begin
      if (r % 3 == 0) step(1, 0, 0, 0, 0);
      for (int k = 0; k < NB; k++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        step((r % 3 != 0) && k == 0, 1, int'(cw[k] / 8) + int'(seed % 301) - 150,
             (seed[7:4] == 4'd3), 0);
        if (seed[9:8] == 2'd1) step(0, 0, 0, 0, 0);
      end
    end

    // R4: out-of-scale sample keeps slot, adds nothing
    peek(3, s0, n0);
    peek(4, s, n);
    step(1, 1, 10, 0, 0);
    step(0, 1, 20, 0, 0);
    step(0, 1, 30, 0, 0);
    step(0, 1, 1000, 1, 0);
    step(0, 1, 40, 0, 0);
    begin
      longint s3, n3, s4, n4;
      peek(3, s3, n3);
      chk("R4 oor cnt", n3, n0);
      chk("R4 oor sum", s3, s0);
      peek(4, s4, n4);
      chk("R4 next slot", s4, s + 40);
    end

    // R6: literal correlation
    step(0, 0, 0, 0, 1);
    step(1, 1, 100, 0, 0);
    step(0, 1, 100, 0, 0);
    peek(0, s, n);
    chk("R6 lit i", longint'($signed(iq_i)), 2963900);
    chk("R6 lit q", longint'($signed(iq_q)), 963000);

    // R7: truncation toward zero, out-of-range select
    step(0, 0, 0, 0, 1);
    step(1, 1, -7, 0, 0);
    step(1, 1, 2, 0, 0);
    peek(0, s, n);
    chk("R7 avg trunc", longint'($signed(rd_avg)), -2);
    peek(11, s, n);
    chk("R7 bad select", s, 0);

    // R8: positive saturation boundary, R5 revolution ceiling
    step(0, 0, 0, 0, 1);
    for (int j = 0; j < 256; j++) step(1, 1, 32767, 0, 0);
    peek(0, s, n);
    chk("R8 no ovf yet", longint'(ovf_flag), 0);
    chk("R8 cnt ceiling", n, 255);
    chk("R5 rev ceiling", longint'(rev_cnt), 15);
    step(1, 1, 32767, 0, 0);
    peek(0, s, n);
    chk("R8 pos clamp", s, 8388607);
    chk("R8 ovf set", longint'(ovf_flag), 1);

    // R8: negative boundary
    step(0, 0, 0, 0, 1);
    for (int j = 0; j < 256; j++) step(1, 1, -32768, 0, 0);
    peek(0, s, n);
    chk("R8 neg exact", s, -8388608);
    chk("R8 neg no ovf", longint'(ovf_flag), 0);
    step(1, 1, -32768, 0, 0);
    peek(0, s, n);
    chk("R8 neg clamp", s, -8388608);
    chk("R8 neg ovf", longint'(ovf_flag), 1);

    // R9: clear beats same-cycle ref and sample, leaves block unarmed
    step(1, 1, 500, 0, 1);
    step(0, 1, 500, 0, 0);
    peek(0, s, n);
    chk("R9 clear cnt", n, 0);
    chk("R9 clear rev", longint'(rev_cnt), 0);
    chk("R9 clear ovf", longint'(ovf_flag), 0);

    step(0, 0, 0, 0, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule